// File: doc/BRIEF.md
# Logarithmic-Depth Prefix Adder

This block adds two unsigned N-bit operands in pure combinational logic and returns the N-bit sum together with the carry leaving the top bit. No carry enters bit 0. Each bit position first forms a generate term, which is set when both operand bits are 1. It also forms a propagate term, which is set when exactly one operand bit is 1.

A recursive prefix tree then merges these (generate, propagate) pairs. The merge operator combines a lower group with the group just above it. The tree splits its span into halves and solves each half on its own. It then folds the combined result of the lower half into every prefix position of the upper half. Because the incoming carry is zero, the prefix generate at position i is exactly the carry out of position i. The carry path is therefore about 2·log2 N gate levels deep, not N.

Each sum bit is the propagate term of its position XORed with the carry coming from the position below. N must be a power of two. Any other width stops elaboration.

Top module: `ppa_adder`

## Requirements
- R1: `sum` equals (`a` + `b`) modulo 2^N for any pair of operands.
- R2: `cout` is 1 exactly when the unsigned value `a` + `b` is 2^N or greater.
- R3: No carry enters bit 0, so `sum[0]` is `a[0]` XOR `b[0]`.
- R4: The carry out of position i equals (a_i AND b_i) OR ((a_i XOR b_i) AND carry out of position i-1). The carry out of position 0 is a_0 AND b_0. The group propagate up to position i is the AND of all per-bit propagate terms from bit 0 to bit i.
- R5: For i ≥ 1, `sum[i]` equals (a_i XOR b_i) XOR the carry out of position i-1.
- R6: A carry generated at bit 0 travels through any number of propagating positions up to `cout`. For example, all-ones plus one gives a zero sum with `cout` = 1.
- R7: The block has no clock or state. The outputs follow a change of the inputs within the same time step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | First unsigned operand |
| b | input | N | Second unsigned operand |
| sum | output | N | Low N bits of a + b |
| cout | output | 1 | Carry out of bit N-1 |

## Verification
Zero operands and complementary alternating patterns (0xAAAA + 0x5555) give all-propagate words that create no carry. They separate the propagate path from the generate path. All-ones plus one, and 2^k-1 plus 1 for each k, move a single generated carry across every span length. This exposes a missing or misplaced fold of the lower half at any level of the recursion. All-ones plus all-ones generates a carry at every bit. A long run of pseudo-random operand pairs is checked against the language's built-in addition. The bench also works out the carries one bit at a time and checks every sum bit against them.

// File: rtl/ppa_pkg.sv
package ppa_pkg;

  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  // Merge a lower group with the group directly above it.
  function automatic gp_t gp_merge(input gp_t lo, input gp_t hi);
    gp_t r;
    r.g = hi.g | (lo.g & hi.p);
    r.p = lo.p & hi.p;
    return r;
  endfunction

endpackage

// File: rtl/ppa_gp_cell.sv
module ppa_gp_cell #(
  parameter int N = 16
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N-1:0] gen,
  output logic [N-1:0] prop
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign gen[i]  = a[i] & b[i];
    assign prop[i] = a[i] ^ b[i];
  end

endmodule

// File: rtl/ppa_prefix_node.sv
module ppa_prefix_node
  import ppa_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] g_in,
  input  logic [W-1:0] p_in,
  output logic [W-1:0] g_out,
  output logic [W-1:0] p_out
);

  localparam int H = W / 2;

  if (W == 1) begin : g_leaf
    assign g_out = g_in;
    assign p_out = p_in;
  end else begin : g_split
    logic [H-1:0] lo_g, lo_p, hi_g, hi_p;

    ppa_prefix_node #(.W(H)) u_lo (
      .g_in (g_in[H-1:0]),
      .p_in (p_in[H-1:0]),
      .g_out(lo_g),
      .p_out(lo_p)
    );

    ppa_prefix_node #(.W(H)) u_hi (
      .g_in (g_in[W-1:H]),
      .p_in (p_in[W-1:H]),
      .g_out(hi_g),
      .p_out(hi_p)
    );

    assign g_out[H-1:0] = lo_g;
    assign p_out[H-1:0] = lo_p;

    // Fold the full lower-half group into each upper prefix.
    for (genvar j = 0; j < H; j++) begin : g_fold
      gp_t merged;
      assign merged = gp_merge(gp_t'{g: lo_g[H-1], p: lo_p[H-1]},
                               gp_t'{g: hi_g[j],   p: hi_p[j]});
      assign g_out[H+j] = merged.g;
      assign p_out[H+j] = merged.p;
    end
  end

endmodule

// File: rtl/ppa_sum_stage.sv
module ppa_sum_stage #(
  parameter int N = 16
) (
  input  logic [N-1:0] prop,
  input  logic [N-1:0] carry,
  output logic [N-1:0] sum,
  output logic         cout
);

  assign sum[0] = prop[0];
  for (genvar i = 1; i < N; i++) begin : g_sum
    assign sum[i] = prop[i] ^ carry[i-1];
  end
  assign cout = carry[N-1];

endmodule

// File: rtl/ppa_adder.sv
module ppa_adder #(
  parameter int N = 16
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N-1:0] sum,
  output logic         cout
);

  localparam bit POW2 = (N > 0) && ((N & (N - 1)) == 0);

  if (!POW2) begin : g_bad_width
    $error("ppa_adder: width N must be a power of two");
  end

  logic [N-1:0] gen, prop;
  logic [N-1:0] carry, grp_prop;

  ppa_gp_cell #(.N(N)) u_gp (
    .a   (a),
    .b   (b),
    .gen (gen),
    .prop(prop)
  );

  ppa_prefix_node #(.W(N)) u_tree (
    .g_in (gen),
    .p_in (prop),
    .g_out(carry),
    .p_out(grp_prop)
  );

  ppa_sum_stage #(.N(N)) u_sum (
    .prop (prop),
    .carry(carry),
    .sum  (sum),
    .cout (cout)
  );

endmodule

// File: rtl/ppa_adder_chk.sv
module ppa_adder_chk #(
  parameter int N = 16
) (
  input logic [N-1:0] a,
  input logic [N-1:0] b,
  input logic [N-1:0] sum,
  input logic         cout,
  input logic [N-1:0] gen,
  input logic [N-1:0] prop,
  input logic [N-1:0] carry,
  input logic [N-1:0] grp_prop
);

  logic [N:0] wide;
  assign wide = {1'b0, a} + {1'b0, b};

  always_comb begin
    // R1
    sum_value_chk: assert (sum == wide[N-1:0]);
    // R2
    carry_out_chk: assert (cout == wide[N]);
    // R3
    bit0_no_cin_chk: assert (sum[0] == (a[0] ^ b[0]));
    // R4
    carry0_chk: assert (carry[0] == gen[0]);
    // R4
    grp_prop0_chk: assert (grp_prop[0] == prop[0]);
    for (int i = 1; i < N; i++) begin
      // R4
      carry_step_chk: assert (carry[i] == (gen[i] | (prop[i] & carry[i-1])));
      // R4
      grp_prop_step_chk: assert (grp_prop[i] == (prop[i] & grp_prop[i-1]));
      // R5
      sum_bit_chk: assert (sum[i] == (prop[i] ^ carry[i-1]));
    end
  end

endmodule

bind ppa_adder ppa_adder_chk #(.N(N)) u_chk (
  .a       (a),
  .b       (b),
  .sum     (sum),
  .cout    (cout),
  .gen     (gen),
  .prop    (prop),
  .carry   (carry),
  .grp_prop(grp_prop)
);

// File: tb/tb_ppa_adder.sv
`timescale 1ns/1ps
module tb_ppa_adder;

  localparam int N = 16;
  localparam logic [N-1:0] ONES = '1;

  logic clk;
  logic [N-1:0] a, b, sum;
  logic cout;
  int checks, failures;
  bit done;

  ppa_adder #(.N(N)) dut (.a(a), .b(b), .sum(sum), .cout(cout));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [N:0] act, input logic [N:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h (a=%h b=%h)", req, act, exp, a, b);
    end
  endtask

  // Drive on falling edge, sample 1 ns later.
  task automatic apply(input logic [N-1:0] x, input logic [N-1:0] y);
    @(negedge clk);
    a = x;
    b = y;
    #1;
  endtask

  task automatic check_full(input string req, input logic [N-1:0] x, input logic [N-1:0] y);
    logic [N:0] exp;
    apply(x, y);
    exp = {1'b0, x} + {1'b0, y};
    check({req, " R1 sum"}, {1'b0, sum}, {1'b0, exp[N-1:0]});
    check({req, " R2 cout"}, {N'(0), cout}, {N'(0), exp[N]});
  endtask

  task automatic t_zero;
    check_full("zero", '0, '0);
  endtask

  task automatic t_alternating;
    check_full("alt", N'(16'hAAAA), N'(16'h5555));
    check({"alt R2 no carry"}, {N'(0), cout}, '0);
  endtask

  task automatic t_full_ripple;
    apply(ONES, N'(1));
    check("R6 ripple sum", {1'b0, sum}, '0);
    check("R6 ripple cout", {N'(0), cout}, {N'(0), 1'b1});
  endtask

  task automatic t_all_generate;
    check_full("allgen", ONES, ONES);
    check("R3 bit0", {N'(0), sum[0]}, '0);
  endtask

  task automatic t_walking;
    for (int k = 1; k <= N; k++) begin
      logic [N-1:0] x;
      x = (k == N) ? ONES : ((N'(1) << k) - N'(1));
      check_full("walk R6", x, N'(1));
    end
  endtask

  task automatic t_bitwise_ripple(input logic [N-1:0] x, input logic [N-1:0] y);
    logic c;
    apply(x, y);
    c = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (i == 0) check("R3 sum0", {N'(0), sum[0]}, {N'(0), x[0] ^ y[0]});
      else        check("R5 sum bit", {N'(0), sum[i]}, {N'(0), x[i] ^ y[i] ^ c});
      c = (x[i] & y[i]) | ((x[i] ^ y[i]) & c);
    end
    check("R4 final carry", {N'(0), cout}, {N'(0), c});
  endtask

  task automatic t_random(input int count);
    logic [31:0] s;
    s = 32'h1234_5678;
    for (int n = 0; n < count; n++) begin
      logic [N-1:0] x, y;
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      x = s[N-1:0];
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      y = s[N-1:0];
      check_full("rand", x, y);
      if (n % 64 == 0) t_bitwise_ripple(x, y);
    end
  endtask

  task automatic t_comb_response;
    apply(N'(3), N'(4));
    a = N'(16'h00FF);
    b = N'(16'h0001);
    #0.1;
    check("R7 same-step", {1'b0, sum}, {1'b0, N'(16'h0100)});
  endtask

  initial begin
    checks = 0;
    failures = 0;
    a = '0;
    b = '0;
    t_zero();
    t_alternating();
    t_full_ripple();
    t_all_generate();
    t_walking();
    t_bitwise_ripple(N'(16'hF0F0), N'(16'h0F11));
    t_comb_response();
    t_random(3000);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule